// File: doc/BRIEF.md
# Pipelined Burst SRAM with Double-Cycle Deselect

This block is a behavioural synchronous static memory with 32-bit words made of four byte lanes. All of its control inputs, the address and the write data are sampled on the rising clock edge. Each edge is classified as one of four cycle types: idle, deselect, read, or write. A selected access continues from edge to edge until a new strobe arrives. Writes update only the chosen lanes of the addressed word. Reads return data through a registered output stage.

An access begins on either of two address strobes. The processor strobe always begins with a read. The controller strobe can write in its own cycle. After a start, a two-bit burst sequencer moves the low address bits in linear or interleaved order while the advance input is held low. Output drive is reported on a separate enable, not on a bidirectional pin. That enable goes off one edge later than the deselect itself. It is held off on the first cycle of an access that starts from the deselected state, and in every cycle after a write. The asynchronous output-enable input gates it at all other times.

Top module: `burst_sram_ctrl`

## Requirements
- R1: A strobe cycle selects the device only when ce1_n=0, ce2=1 and ce3_n=0. A recognised strobe with any enable inactive is a deselect, and it writes nothing.
- R2: When both strobes are low, the processor strobe wins. pstb_n is ignored while ce1_n=1, so a low pstb_n alone with ce1_n=1 neither starts nor ends an access.
- R3: A cycle started by pstb_n is a read, whatever gw_n, bwe_n and bsel_n are. A write to that address follows on the next edge, with both strobes high and a write requested.
- R4: A cycle with cstb_n low, pstb_n not recognised, the device selected and a write requested stores the data at addr on that same edge.
- R5: gw_n=0 writes all four lanes. Otherwise, bwe_n=0 writes lane i (wdata bits 8i+7:8i) only where bsel_n[i]=0. With bwe_n=1 (and gw_n=1) the cycle is a read. Lanes that are not written keep their contents.
- R6: Data for an address sampled at edge k is on rdata with drive_en=1 (when oe_n=0) after edge k+1.
- R7: While an access continues, adv_n=0 steps the two low address bits from the start value b. In linear order (burst_ilv=0) the i-th address is (b+i) mod 4. In interleaved order (burst_ilv=1) it is b XOR i. adv_n=1 holds the address. The upper address bits never change during a burst.
- R8: After a deselect is sampled at edge k, drive_en stays as it was after edge k and is 0 after edge k+1.
- R9: A read that starts from the deselected state leaves drive_en=0 for the cycle after its start edge, whatever oe_n is.
- R10: drive_en is 0 after any edge that performs a write, whatever oe_n is.
- R11: oe_n is asynchronous and active low. When output data is pending, drive_en follows oe_n without waiting for a clock edge.
- R12: rst_n low clears the pipeline at once (drive_en=0, deselected). It leaves the array contents intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low pipeline reset |
| addr | input | ADDR_W | Word address, sampled on a strobe |
| ce1_n | input | 1 | Chip enable, active low; also qualifies the processor strobe |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| pstb_n | input | 1 | Processor address strobe, active low |
| cstb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write of all lanes, active low |
| bwe_n | input | 1 | Byte write enable, active low |
| bsel_n | input | 4 | Per-lane write selects, active low |
| burst_ilv | input | 1 | Burst order: 1 interleaved, 0 linear |
| wdata | input | DATA_W | Write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| rdata | output | DATA_W | Registered read data |
| drive_en | output | 1 | High when the output drivers would be on |

## Verification
The bound checker tests the drive rules on every cycle. These are: float after a write, the two-edge turn-off after a deselect, the mask on the first cycle out of deselect, and the one-stage read latency against oe_n. It also tests that the processor strobe never produces a write, including when both strobes are low. Data-path results need directed scenarios that compare rdata against a lane-accurate model kept in the bench. These include which lanes a write touched, linear and interleaved burst order, and writes blocked by a disabled chip enable. So do a two-cycle processor-strobe write, asynchronous oe_n toggling, and array retention across reset.

// File: rtl/bsram_pkg.sv
package bsram_pkg;
    localparam int LANE_W  = 8;
    localparam int BURST_W = 2;

    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,
        CYC_DESEL = 2'd1,
        CYC_READ  = 2'd2,
        CYC_WRITE = 2'd3
    } cyc_e;
endpackage

// File: rtl/bsram_burst_seq.sv
module bsram_burst_seq
    import bsram_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               adv,
    input  logic               interleave,
    input  logic [BURST_W-1:0] seed,
    output logic [BURST_W-1:0] next_lsb
);
    typedef struct packed {
        logic [BURST_W-1:0] base;
        logic [BURST_W-1:0] cnt;
    } seq_t;

    seq_t               s_d, s_q;
    logic [BURST_W-1:0] cnt_inc;

    always_comb begin
        cnt_inc = s_q.cnt + BURST_W'(1);
        if (interleave) next_lsb = s_q.base ^ cnt_inc;
        else            next_lsb = s_q.base + cnt_inc;
        s_d = s_q;
        if (load) begin
            s_d.base = seed;
            s_d.cnt  = '0;
        end else if (adv) begin
            s_d.cnt = cnt_inc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/bsram_cycle_decode.sv
module bsram_cycle_decode
    import bsram_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             ce1_n,
    input  logic             ce2,
    input  logic             ce3_n,
    input  logic             pstb_n,
    input  logic             cstb_n,
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] bsel_n,
    input  logic             active,
    output cyc_e             cyc,
    output logic             strobe,
    output logic             sel,
    output logic [LANES-1:0] wmask
);
    logic             p_hit, c_hit, wr_req;
    logic [LANES-1:0] raw_mask;

    always_comb begin
        p_hit  = !pstb_n && !ce1_n;
        c_hit  = !cstb_n && !p_hit;
        strobe = p_hit || c_hit;
        sel    = !ce1_n && ce2 && !ce3_n;

        if (!gw_n)       raw_mask = '1;
        else if (!bwe_n) raw_mask = ~bsel_n;
        else             raw_mask = '0;
        wr_req = |raw_mask;

        if (strobe) begin
            if (!sel)       cyc = CYC_DESEL;
            else if (p_hit) cyc = CYC_READ;
            else            cyc = wr_req ? CYC_WRITE : CYC_READ;
        end else if (active) begin
            cyc = wr_req ? CYC_WRITE : CYC_READ;
        end else begin
            cyc = CYC_IDLE;
        end

        wmask = (cyc == CYC_WRITE) ? raw_mask : '0;
    end
endmodule

// File: rtl/bsram_lane_array.sv
module bsram_lane_array
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4
) (
    input  logic                     clk,
    input  logic [LANES-1:0]         wmask,
    input  logic [ADDR_W-1:0]        waddr,
    input  logic [LANES*LANE_W-1:0]  wdata,
    input  logic [ADDR_W-1:0]        raddr,
    output logic [LANES*LANE_W-1:0]  rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];

        always_ff @(posedge clk) begin
            if (wmask[g]) cells[waddr] <= wdata[g*LANE_W +: LANE_W];
        end

        assign rdata[g*LANE_W +: LANE_W] = cells[raddr];
    end
endmodule

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
    import bsram_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        addr,
    input  logic                     ce1_n,
    input  logic                     ce2,
    input  logic                     ce3_n,
    input  logic                     pstb_n,
    input  logic                     cstb_n,
    input  logic                     adv_n,
    input  logic                     gw_n,
    input  logic                     bwe_n,
    input  logic [DATA_W/8-1:0]      bsel_n,
    input  logic                     burst_ilv,
    input  logic [DATA_W-1:0]        wdata,
    input  logic                     oe_n,
    output logic [DATA_W-1:0]        rdata,
    output logic                     drive_en
);
    localparam int LANES = DATA_W / LANE_W;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              act;
        logic              rd;
        logic [DATA_W-1:0] dout;
        logic              dv;
    } pipe_t;

    pipe_t              st_d, st_q;
    cyc_e               cyc_w;
    logic               strobe_w, sel_w, load_w, adv_w, act_w;
    logic [LANES-1:0]   wmask_w;
    logic [BURST_W-1:0] nxt_lsb_w;
    logic [ADDR_W-1:0]  eff_addr_w;
    logic [DATA_W-1:0]  arr_q_w;

    assign act_w  = st_q.act;
    assign load_w = strobe_w && sel_w;
    assign adv_w  = !strobe_w && st_q.act && !adv_n;

    bsram_cycle_decode #(.LANES(LANES)) u_dec (
        .ce1_n (ce1_n),
        .ce2   (ce2),
        .ce3_n (ce3_n),
        .pstb_n(pstb_n),
        .cstb_n(cstb_n),
        .gw_n  (gw_n),
        .bwe_n (bwe_n),
        .bsel_n(bsel_n),
        .active(st_q.act),
        .cyc   (cyc_w),
        .strobe(strobe_w),
        .sel   (sel_w),
        .wmask (wmask_w)
    );

    bsram_burst_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load_w),
        .adv       (adv_w),
        .interleave(burst_ilv),
        .seed      (addr[BURST_W-1:0]),
        .next_lsb  (nxt_lsb_w)
    );

    bsram_lane_array #(.ADDR_W(ADDR_W), .LANES(LANES)) u_arr (
        .clk  (clk),
        .wmask(wmask_w),
        .waddr(eff_addr_w),
        .wdata(wdata),
        .raddr(st_q.addr),
        .rdata(arr_q_w)
    );

    always_comb begin
        if (load_w)     eff_addr_w = addr;
        else if (adv_w) eff_addr_w = {st_q.addr[ADDR_W-1:BURST_W], nxt_lsb_w};
        else            eff_addr_w = st_q.addr;

        st_d      = st_q;
        st_d.addr = eff_addr_w;
        st_d.act  = strobe_w ? sel_w : st_q.act;
        st_d.rd   = (cyc_w == CYC_READ);
        st_d.dout = st_q.rd ? arr_q_w : st_q.dout;
        st_d.dv   = st_q.rd && (cyc_w != CYC_WRITE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata    = st_q.dout;
    assign drive_en = st_q.dv && !oe_n;
endmodule

// File: rtl/bsram_chk.sv
module bsram_chk
    import bsram_pkg::*;
(
    input logic clk,
    input logic rst_n,
    input logic oe_n,
    input logic ce1_n,
    input logic pstb_n,
    input logic drive_en,
    input logic act,
    input cyc_e cyc
);
    AST_PSTROBE_READS: assert property (@(posedge clk) disable iff (!rst_n)
        (!pstb_n && !ce1_n) |-> (cyc != CYC_WRITE)); // R3

    AST_PSTROBE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (!pstb_n && !ce1_n && act) |-> (cyc inside {CYC_READ, CYC_DESEL})); // R2

    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == CYC_READ) ##1 (cyc != CYC_WRITE) |=> (drive_en == !oe_n)); // R6

    AST_DESEL_TWO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == CYC_DESEL) |=> ##1 !drive_en); // R8

    AST_FIRST_CYCLE_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (!act && cyc == CYC_READ) |=> !drive_en); // R9

    AST_WRITE_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc == CYC_WRITE) |=> !drive_en); // R10
endmodule

bind burst_sram_ctrl bsram_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .oe_n    (oe_n),
    .ce1_n   (ce1_n),
    .pstb_n  (pstb_n),
    .drive_en(drive_en),
    .act     (act_w),
    .cyc     (cyc_w)
);

// File: tb/sim_burst_sram_ctrl.sv
module sim_burst_sram_ctrl;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  addr = '0;
    logic        ce1_n = 1'b1, ce2 = 1'b1, ce3_n = 1'b0;
    logic        pstb_n = 1'b1, cstb_n = 1'b1, adv_n = 1'b1;
    logic        gw_n = 1'b1, bwe_n = 1'b1;
    logic [3:0]  bsel_n = 4'hF;
    logic        burst_ilv = 1'b0;
    logic [31:0] wdata = '0;
    logic        oe_n = 1'b0;
    logic [31:0] rdata;
    logic        drive_en;

    int checks = 0;
    int fails  = 0;
    logic [31:0] model [256];

    always #(CLK_P/2) clk = ~clk;

    burst_sram_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr), .ce1_n(ce1_n), .ce2(ce2),
        .ce3_n(ce3_n), .pstb_n(pstb_n), .cstb_n(cstb_n), .adv_n(adv_n),
        .gw_n(gw_n), .bwe_n(bwe_n), .bsel_n(bsel_n), .burst_ilv(burst_ilv),
        .wdata(wdata), .oe_n(oe_n), .rdata(rdata), .drive_en(drive_en)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        pstb_n = 1'b1; cstb_n = 1'b1; adv_n = 1'b1;
        gw_n = 1'b1; bwe_n = 1'b1; bsel_n = 4'hF;
        ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0;
    endtask

    task automatic desel();
        idle();
        ce1_n = 1'b1; cstb_n = 1'b0;
        step();
        idle();
    endtask

    task automatic wr_c(input logic [7:0] a, input logic [31:0] d,
                        input logic g, input logic b, input logic [3:0] s);
        idle();
        addr = a; wdata = d; cstb_n = 1'b0; gw_n = g; bwe_n = b; bsel_n = s;
        step();
        for (int i = 0; i < 4; i++)
            if (!g || (!b && !s[i])) model[a][8*i +: 8] = d[8*i +: 8];
        desel();
    endtask

    task automatic rd_chk(input logic [7:0] a, input string req);
        idle();
        addr = a; pstb_n = 1'b0;
        step();
        chk(drive_en == 1'b0, "R9 first cycle masked", {31'b0, drive_en}, 32'h0);
        idle();
        step();
        chk(drive_en === 1'b1 && rdata === model[a], req, rdata, model[a]);
        desel();
        chk(drive_en == 1'b1, "R8 still driven after deselect edge", {31'b0, drive_en}, 32'h1);
        step();
        chk(drive_en == 1'b0, "R8 floated one edge later", {31'b0, drive_en}, 32'h0);
    endtask

    task automatic t_reset();
        chk(drive_en == 1'b0, "R12 reset drive off", {31'b0, drive_en}, 32'h0);
    endtask

    task automatic t_word_writes();
        wr_c(8'h10, 32'hCAFE0001, 1'b0, 1'b1, 4'hF);
        wr_c(8'h11, 32'h5A5A1234, 1'b0, 1'b0, 4'hA);
        rd_chk(8'h10, "R4 controller write then read");
        rd_chk(8'h11, "R5 global write overrides byte selects");
    endtask

    task automatic t_byte_writes();
        wr_c(8'h20, 32'h11223344, 1'b1, 1'b0, 4'b0000);
        wr_c(8'h20, 32'hAABBCCDD, 1'b1, 1'b0, 4'b1010);
        rd_chk(8'h20, "R5 lanes 0 and 2 written");
        wr_c(8'h20, 32'hFFFFFFFF, 1'b1, 1'b1, 4'b0000);
        rd_chk(8'h20, "R5 bwe_n high writes nothing");
        wr_c(8'h20, 32'h99000000, 1'b1, 1'b0, 4'b0111);
        rd_chk(8'h20, "R5 single top lane");
    endtask

    task automatic t_pstrobe_write();
        wr_c(8'h30, 32'h01020304, 1'b0, 1'b1, 4'hF);
        idle();
        addr = 8'h30; pstb_n = 1'b0; gw_n = 1'b0; wdata = 32'hDEAD0000;
        step();
        idle();
        gw_n = 1'b0; wdata = 32'h76543210; addr = 8'hFF;
        step();
        model[8'h30] = 32'h76543210;
        chk(drive_en == 1'b0, "R10 write cycle floats with oe_n low", {31'b0, drive_en}, 32'h0);
        desel();
        rd_chk(8'h30, "R3 two-cycle processor-strobe write");
    endtask

    task automatic t_priority();
        wr_c(8'h40, 32'h0BADF00D, 1'b0, 1'b1, 4'hF);
        idle();
        addr = 8'h40; pstb_n = 1'b0; cstb_n = 1'b0; gw_n = 1'b0; wdata = 32'hFFFF0000;
        step();
        idle();
        step();
        chk(drive_en === 1'b1 && rdata === model[8'h40], "R2 both strobes read", rdata, model[8'h40]);
        ce1_n = 1'b1; pstb_n = 1'b0;
        step();
        step();
        chk(drive_en == 1'b1, "R2 pstb_n ignored with ce1_n high", {31'b0, drive_en}, 32'h1);
        desel();
        step();
        rd_chk(8'h40, "R2 no write from combined strobes");
    endtask

    task automatic t_enables();
        wr_c(8'h50, 32'h13572468, 1'b0, 1'b1, 4'hF);
        idle();
        ce2 = 1'b0; addr = 8'h50; cstb_n = 1'b0; gw_n = 1'b0; wdata = 32'h0;
        step();
        idle();
        step();
        chk(drive_en == 1'b0, "R1 ce2 low deselects", {31'b0, drive_en}, 32'h0);
        ce3_n = 1'b1; addr = 8'h50; cstb_n = 1'b0; gw_n = 1'b0; wdata = 32'h1;
        step();
        idle();
        rd_chk(8'h50, "R1 disabled enable blocks write");
    endtask

    task automatic t_burst(input logic ilv, input logic [7:0] start);
        logic [7:0] grp;
        grp = {start[7:2], 2'b00};
        for (int j = 0; j < 4; j++)
            wr_c(grp + 8'(j), 32'hB0000000 + {24'h0, grp} * 32'h100 + 32'(j), 1'b0, 1'b1, 4'hF);
        burst_ilv = ilv;
        idle();
        addr = start; pstb_n = 1'b0;
        step();
        idle();
        for (int i = 0; i < 4; i++) begin
            logic [1:0] lsb;
            logic [7:0] ea;
            adv_n = (i < 3) ? 1'b0 : 1'b1;
            step();
            lsb = ilv ? (start[1:0] ^ 2'(i)) : (start[1:0] + 2'(i));
            ea = {start[7:2], lsb};
            chk(rdata === model[ea] && drive_en === 1'b1,
                ilv ? "R7 interleaved order" : "R7 linear order", rdata, model[ea]);
        end
        begin
            logic [1:0] hl;
            logic [7:0] ha;
            hl = ilv ? (start[1:0] ^ 2'd3) : (start[1:0] + 2'd3);
            ha = {start[7:2], hl};
            step();
            chk(rdata === model[ha], "R7 adv_n high holds", rdata, model[ha]);
        end
        desel();
        step();
    endtask

    task automatic t_oe();
        wr_c(8'h60, 32'h600DCAFE, 1'b0, 1'b1, 4'hF);
        idle();
        addr = 8'h60; pstb_n = 1'b0;
        step();
        idle();
        step();
        oe_n = 1'b1;
        #1;
        chk(drive_en == 1'b0, "R11 oe_n high floats at once", {31'b0, drive_en}, 32'h0);
        oe_n = 1'b0;
        #1;
        chk(drive_en == 1'b1, "R11 oe_n low drives at once", {31'b0, drive_en}, 32'h1);
        oe_n = 1'b1;
        desel();
        oe_n = 1'b0;
        step();
    endtask

    task automatic t_reset_keep();
        wr_c(8'h70, 32'h7777AAAA, 1'b0, 1'b1, 4'hF);
        idle();
        addr = 8'h70; pstb_n = 1'b0;
        step();
        idle();
        step();
        rst_n = 1'b0;
        #1;
        chk(drive_en == 1'b0, "R12 reset clears drive", {31'b0, drive_en}, 32'h0);
        step();
        rst_n = 1'b1;
        step();
        rd_chk(8'h70, "R12 array kept through reset");
    endtask

    initial begin
        idle();
        ce1_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        step();
        t_word_writes();
        t_byte_writes();
        t_pstrobe_write();
        t_priority();
        t_enables();
        t_burst(1'b0, 8'h86);
        t_burst(1'b1, 8'h95);
        t_oe();
        t_reset_keep();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_P * 20000);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule